// File: doc/BRIEF.md
# Prioritized Interrupt Vector Resolver

This block chooses one winning interrupt line for each of two classes, the normal class and the fast class. It works on up to three banks of 32 lines. For every line it receives a pending bit, a mask bit, a class-steering bit and a priority value. A line takes part in a class when it is pending, it is not masked, and its steering bit selects that class. Among the lines that take part, the one with the smallest priority value wins. When several lines share that value, the line with the highest global index wins.

The search is combinational and completes within one cycle. Each class has its own "any eligible" flag, which follows the inputs in the same cycle. The winning line number for a class goes into an output register only when the load strobe for that class is high. The surrounding controller handles register decoding, edge capture and the request handshake toward the processor.

Top module: `irq_vec_resolver`

## Requirements
- R1: A line is eligible for the fast class when pending=1, mask=0 and steer=1. It is eligible for the normal class when pending=1, mask=0 and steer=0. A masked line or a line that is not pending never wins.
- R2: Among the eligible lines of a class, the line with the numerically smallest priority value wins. The priority of line i is taken from bits [i*PRIO_W +: PRIO_W] of prio_i.
- R3: When eligible lines share the smallest priority value, the line with the largest global index wins. This holds across bank boundaries.
- R4: The reported code is 32*bank + bit, which is the global line index. Bit i of each line vector is line i.
- R5: When a class has no eligible line, a load for that class writes code 0.
- R6: A class's code register changes only on a clock edge at which that class's load strobe is 1. At every other edge it holds its value.
- R7: The any flag of a class is the OR of that class's eligible lines. It is combinational and reflects the current inputs before any clock edge.
- R8: Lines in banks with an index of NUM_BANKS or more are never eligible, and no code of NUM_BANKS*32 or more is ever reported.
- R9: While rst_ni is low, both code registers are 0. They clear asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 96 | Pending bit per line |
| mask_i | input | 96 | Mask bit per line (1 = masked) |
| steer_i | input | 96 | Class steering per line (1 = fast, 0 = normal) |
| prio_i | input | 96*PRIO_W | Priority per line, line i at [i*PRIO_W +: PRIO_W] |
| load_irq_i | input | 1 | Capture the normal-class winner |
| load_fiq_i | input | 1 | Capture the fast-class winner |
| irq_code_o | output | 7 | Registered normal-class winning line |
| fiq_code_o | output | 7 | Registered fast-class winning line |
| irq_any_o | output | 1 | Some line is eligible for the normal class |
| fiq_any_o | output | 1 | Some line is eligible for the fast class |

## Verification
The bench builds two instances. The first uses NUM_BANKS=3 and PRIO_W=6. It exercises ties that cross bank boundaries, the top line 95, and the extremes of the 6-bit priority range. The second uses NUM_BANKS=1 and PRIO_W=5. In that instance, lines in the unused upper banks must stay invisible even when they are pending and have the most urgent priority. Its 5-bit field is checked at its top two values.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int unsigned LINES_PER_BANK = 32;
  localparam int unsigned MAX_BANKS      = 3;
  localparam int unsigned MAX_LINES      = LINES_PER_BANK * MAX_BANKS;
  localparam int unsigned CODE_W         = $clog2(MAX_LINES);
  localparam int unsigned NUM_CLASS      = 2;

  typedef enum logic {CLS_IRQ = 1'b0, CLS_FIQ = 1'b1} irq_class_e;
endpackage

// File: rtl/irq_res_elig.sv
module irq_res_elig
  import irq_res_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3
) (
  input  logic [MAX_LINES-1:0] pend_i,
  input  logic [MAX_LINES-1:0] mask_i,
  input  logic [MAX_LINES-1:0] steer_i,
  output logic [MAX_LINES-1:0] elig_irq_o,
  output logic [MAX_LINES-1:0] elig_fiq_o
);
  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    localparam int unsigned LO = b * LINES_PER_BANK;
    if (b < NUM_BANKS) begin : g_used
      logic [LINES_PER_BANK-1:0] live;
      assign live = pend_i[LO +: LINES_PER_BANK] & ~mask_i[LO +: LINES_PER_BANK];
      assign elig_irq_o[LO +: LINES_PER_BANK] = live & ~steer_i[LO +: LINES_PER_BANK];
      assign elig_fiq_o[LO +: LINES_PER_BANK] = live &  steer_i[LO +: LINES_PER_BANK];
    end else begin : g_unused
      assign elig_irq_o[LO +: LINES_PER_BANK] = '0;
      assign elig_fiq_o[LO +: LINES_PER_BANK] = '0;
    end
  end
endmodule

// File: rtl/irq_res_tree.sv
module irq_res_tree
  import irq_res_pkg::*;
#(
  parameter int unsigned PRIO_W = 6
) (
  input  logic [MAX_LINES-1:0]        elig_i,
  input  logic [MAX_LINES*PRIO_W-1:0] prio_i,
  output logic                        any_o,
  output logic [CODE_W-1:0]           win_o
);
  localparam int unsigned LEAVES = 1 << $clog2(MAX_LINES);
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [CODE_W-1:0] ni [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < MAX_LINES) begin : g_real
      assign nv[LEAVES-1+i] = elig_i[i];
      assign np[LEAVES-1+i] = prio_i[i*PRIO_W +: PRIO_W];
      assign ni[LEAVES-1+i] = CODE_W'(i);
    end else begin : g_pad
      assign nv[LEAVES-1+i] = 1'b0;
      assign np[LEAVES-1+i] = '1;
      assign ni[LEAVES-1+i] = '0;
    end
  end

  // Left child holds lower indices; right wins on equal priority.
  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_r;
    assign take_r = nv[2*k+2] && (!nv[2*k+1] || (np[2*k+2] <= np[2*k+1]));
    assign nv[k]  = nv[2*k+1] | nv[2*k+2];
    assign np[k]  = take_r ? np[2*k+2] : np[2*k+1];
    assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
  end

  assign any_o = nv[0];
  assign win_o = nv[0] ? ni[0] : '0;
endmodule

// File: rtl/irq_res_code_reg.sv
module irq_res_code_reg
  import irq_res_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] win_i,
  output logic [CODE_W-1:0] code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_o <= '0;
    else if (load_i) code_o <= win_i;
  end
endmodule

// File: rtl/irq_vec_resolver.sv
module irq_vec_resolver
  import irq_res_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned PRIO_W    = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [MAX_LINES-1:0]        pend_i,
  input  logic [MAX_LINES-1:0]        mask_i,
  input  logic [MAX_LINES-1:0]        steer_i,
  input  logic [MAX_LINES*PRIO_W-1:0] prio_i,
  input  logic                        load_irq_i,
  input  logic                        load_fiq_i,
  output logic [CODE_W-1:0]           irq_code_o,
  output logic [CODE_W-1:0]           fiq_code_o,
  output logic                        irq_any_o,
  output logic                        fiq_any_o
);
  logic [MAX_LINES-1:0] elig [NUM_CLASS];
  logic                 any  [NUM_CLASS];
  logic [CODE_W-1:0]    win  [NUM_CLASS];
  logic [CODE_W-1:0]    code [NUM_CLASS];
  logic                 load [NUM_CLASS];

  assign load[CLS_IRQ] = load_irq_i;
  assign load[CLS_FIQ] = load_fiq_i;

  irq_res_elig #(.NUM_BANKS(NUM_BANKS)) u_elig (
    .pend_i     (pend_i),
    .mask_i     (mask_i),
    .steer_i    (steer_i),
    .elig_irq_o (elig[CLS_IRQ]),
    .elig_fiq_o (elig[CLS_FIQ])
  );

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    irq_res_tree #(.PRIO_W(PRIO_W)) u_tree (
      .elig_i (elig[c]),
      .prio_i (prio_i),
      .any_o  (any[c]),
      .win_o  (win[c])
    );
    irq_res_code_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load[c]),
      .win_i  (win[c]),
      .code_o (code[c])
    );
  end

  assign irq_code_o = code[CLS_IRQ];
  assign fiq_code_o = code[CLS_FIQ];
  assign irq_any_o  = any[CLS_IRQ];
  assign fiq_any_o  = any[CLS_FIQ];
endmodule

// File: rtl/irq_vec_resolver_chk.sv
module irq_vec_resolver_chk
  import irq_res_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [MAX_LINES-1:0] pend_i,
  input logic [MAX_LINES-1:0] mask_i,
  input logic [MAX_LINES-1:0] steer_i,
  input logic                 load_irq_i,
  input logic                 load_fiq_i,
  input logic [CODE_W-1:0]    irq_code_o,
  input logic [CODE_W-1:0]    fiq_code_o,
  input logic                 irq_any_o,
  input logic                 fiq_any_o
);
  localparam int unsigned PADDED = 1 << CODE_W;
  localparam logic [CODE_W:0] LIMIT = (CODE_W+1)'(NUM_BANKS * LINES_PER_BANK);

  logic [PADDED-1:0] irq_ok_q, fiq_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_ok_q <= '0;
      fiq_ok_q <= '0;
    end else begin
      irq_ok_q <= PADDED'(pend_i & ~mask_i & ~steer_i);
      fiq_ok_q <= PADDED'(pend_i & ~mask_i &  steer_i);
    end
  end

  assert_irq_winner_live_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_irq_i && irq_any_o |=> irq_ok_q[irq_code_o]);
  assert_fiq_winner_live_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fiq_i && fiq_any_o |=> fiq_ok_q[fiq_code_o]);
  assert_irq_empty_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_irq_i && !irq_any_o |=> irq_code_o == '0);
  assert_fiq_empty_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_fiq_i && !fiq_any_o |=> fiq_code_o == '0);
  assert_irq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_irq_i |=> $stable(irq_code_o));
  assert_fiq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_fiq_i |=> $stable(fiq_code_o));
  assert_code_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, irq_code_o} < LIMIT) && ({1'b0, fiq_code_o} < LIMIT));
endmodule

bind irq_vec_resolver irq_vec_resolver_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pend_i     (pend_i),
  .mask_i     (mask_i),
  .steer_i    (steer_i),
  .load_irq_i (load_irq_i),
  .load_fiq_i (load_fiq_i),
  .irq_code_o (irq_code_o),
  .fiq_code_o (fiq_code_o),
  .irq_any_o  (irq_any_o),
  .fiq_any_o  (fiq_any_o)
);

// File: tb/irq_vec_resolver_tb_top.sv
module irq_vec_resolver_tb_top;
  localparam int NL  = 96;
  localparam int PW  = 6;
  localparam int PW1 = 5;

  typedef struct packed {
    logic       en;
    logic [6:0] idx;
    logic [5:0] pr;
    logic       fq;
    logic       mk;
  } line_t;

  typedef struct packed {
    line_t [2:0] ln;
    logic [6:0]  ei;
    logic        ea;
    logic [6:0]  ef;
    logic        fa;
  } vec_t;

  function automatic line_t mkl(int idx, int pr, bit fq, bit mk);
    mkl = '{en: 1'b1, idx: 7'(idx), pr: 6'(pr), fq: fq, mk: mk};
  endfunction

  function automatic vec_t mkv(line_t a, line_t b, line_t c, int ei, bit ea, int ef, bit fa);
    mkv = '{ln: {c, b, a}, ei: 7'(ei), ea: ea, ef: 7'(ef), fa: fa};
  endfunction

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    mkv(mkl(5,3,0,0),   '0,               '0,             5, 1,  0, 0), // R1 R4
    mkv(mkl(40,10,0,0), mkl(70,2,0,0),    '0,            70, 1,  0, 0), // R2 R4
    mkv(mkl(10,4,0,0),  mkl(20,4,0,0),    '0,            20, 1,  0, 0), // R3
    mkv(mkl(90,7,1,0),  mkl(3,1,1,0),     '0,             0, 0,  3, 1), // R1 R2
    mkv(mkl(33,0,0,1),  mkl(34,9,0,0),    '0,            34, 1,  0, 0), // R1 mask
    mkv(mkl(95,63,0,0), mkl(0,62,0,0),    mkl(64,5,1,0),  0, 1, 64, 1), // R2 extremes
    mkv(mkl(31,0,0,0),  mkl(32,0,0,0),    '0,            32, 1,  0, 0), // R3 cross bank
    mkv(mkl(7,0,0,1),   mkl(50,3,1,1),    '0,             0, 0,  0, 0), // R5
    mkv(mkl(95,0,0,0),  mkl(94,0,0,0),    mkl(0,0,1,0),  95, 1,  0, 1)  // R3 R7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] pend = '0, mask = '0, steer = '0;
  logic [NL*PW-1:0] prio = '0;
  logic [NL-1:0] pend1 = '0, mask1 = '0, steer1 = '0;
  logic [NL*PW1-1:0] prio1 = '0;
  logic ld_irq = 1'b0, ld_fiq = 1'b0;
  logic [6:0] irq_code, fiq_code, irq_code1, fiq_code1;
  logic irq_any, fiq_any, irq_any1, fiq_any1;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  irq_vec_resolver #(.NUM_BANKS(3), .PRIO_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .mask_i(mask), .steer_i(steer),
    .prio_i(prio), .load_irq_i(ld_irq), .load_fiq_i(ld_fiq),
    .irq_code_o(irq_code), .fiq_code_o(fiq_code), .irq_any_o(irq_any), .fiq_any_o(fiq_any));

  irq_vec_resolver #(.NUM_BANKS(1), .PRIO_W(PW1)) dut_b1_i (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend1), .mask_i(mask1), .steer_i(steer1),
    .prio_i(prio1), .load_irq_i(ld_irq), .load_fiq_i(ld_fiq),
    .irq_code_o(irq_code1), .fiq_code_o(fiq_code1), .irq_any_o(irq_any1), .fiq_any_o(fiq_any1));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_vec(vec_t v);
    pend = '0; mask = '0; steer = '0; prio = '0;
    for (int k = 0; k < 3; k++) begin
      if (v.ln[k].en) begin
        pend[v.ln[k].idx]  = 1'b1;
        mask[v.ln[k].idx]  = v.ln[k].mk;
        steer[v.ln[k].idx] = v.ln[k].fq;
        prio[v.ln[k].idx*PW +: PW] = v.ln[k].pr;
      end
    end
  endtask

  // Drive at negedge with strobes, capture at posedge, return at next negedge.
  task automatic apply(vec_t v, bit li, bit lf);
    @(negedge clk);
    set_vec(v);
    ld_irq = li; ld_fiq = lf;
    @(negedge clk);
    ld_irq = 1'b0; ld_fiq = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    chk("R9 reset irq code", irq_code, 0);
    chk("R9 reset fiq code", fiq_code, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle irq any", irq_any, 0);
    chk("R7 idle fiq any", fiq_any, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i], 1'b1, 1'b1);
      chk($sformatf("R2 R3 R4 vec%0d irq code", i), irq_code, VEC[i].ei);
      chk($sformatf("R7 vec%0d irq any", i), irq_any, VEC[i].ea);
      chk($sformatf("R1 R5 vec%0d fiq code", i), fiq_code, VEC[i].ef);
      chk($sformatf("R7 vec%0d fiq any", i), fiq_any, VEC[i].fa);
    end

    // R6: strobes are per class
    apply(VEC[5], 1'b1, 1'b1);
    apply(VEC[3], 1'b1, 1'b0);
    chk("R6 irq loaded alone", irq_code, 0);
    chk("R6 fiq held", fiq_code, 64);
    apply(VEC[1], 1'b0, 1'b0);
    chk("R6 irq held no strobe", irq_code, 0);
    chk("R6 fiq held no strobe", fiq_code, 64);
    apply(VEC[1], 1'b0, 1'b1);
    chk("R6 fiq loaded alone", fiq_code, 0);
    chk("R6 irq held", irq_code, 0);

    // R7: flag follows inputs before any edge
    @(negedge clk);
    set_vec(VEC[0]);
    #1 chk("R7 same-cycle irq any", irq_any, 1);
    set_vec(VEC[7]);
    #1 chk("R7 same-cycle irq any drop", irq_any, 0);

    // R9: asynchronous clear mid-run
    apply(VEC[6], 1'b1, 1'b0);
    chk("R9 pre-reset irq", irq_code, 32);
    #2 rst_n = 1'b0;
    #1 chk("R9 async clear", irq_code, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8 / R2 on single-bank, 5-bit instance
    @(negedge clk);
    pend1 = '0; pend1[40] = 1'b1; pend1[2] = 1'b1;
    prio1 = '0; prio1[2*PW1 +: PW1] = 5'd31;
    ld_irq = 1'b1;
    @(negedge clk);
    ld_irq = 1'b0;
    chk("R8 upper bank ignored", irq_code1, 2);
    @(negedge clk);
    pend1 = '0; pend1[40] = 1'b1; pend1[80] = 1'b1; steer1[80] = 1'b1;
    #1 chk("R8 upper bank irq any", irq_any1, 0);
    chk("R8 upper bank fiq any", fiq_any1, 0);
    ld_irq = 1'b1; ld_fiq = 1'b1;
    @(negedge clk);
    ld_irq = 1'b0; ld_fiq = 1'b0;
    chk("R8 upper bank code", irq_code1, 0);
    @(negedge clk);
    pend1 = '0; steer1 = '0; pend1[1] = 1'b1; pend1[2] = 1'b1;
    prio1 = '0; prio1[1*PW1 +: PW1] = 5'd30; prio1[2*PW1 +: PW1] = 5'd31;
    ld_irq = 1'b1;
    @(negedge clk);
    ld_irq = 1'b0;
    chk("R2 5-bit field top values", irq_code1, 1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule